// File: doc/BRIEF.md
# Saturating Scalar ALU with Sticky Overflow Flag

This block is a 32-bit signed arithmetic unit whose result never wraps. When the exact result of an operation falls outside the signed 32-bit range, the unit returns the nearest limit instead: 0x7FFFFFFF above the range, 0x80000000 below it. The operations are add, subtract, left shift, narrowing of a 40-bit value built from an 8-bit extension and a 32-bit word, and a fractional 16x16 multiply. The multiply doubles the signed product of two selected halves. The result path is combinational, so it is valid in the same cycle as the operands.

Every operation that is issued with `opValid` high and clamps sets one shared sticky flag. The flag sits in a 32-bit status register and holds until software writes that bit back to zero. Control code runs a series of operations and then reads the status once to learn whether any of them clipped. The status register can be written and read back at any time.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 adds `opA` and `opB` as signed values. A sum above 0x7FFFFFFF returns 0x7FFFFFFF and a sum below -2^31 returns 0x80000000 (0x51510000 + 0x51515454 gives 0x7FFFFFFF). Any other sum is returned exactly.
- R2: Opcode 1 returns `opA` minus `opB` and clamps in the same way (3 - 0x80000003 gives 0x7FFFFFFF).
- R3: Opcode 2 shifts `opA` left by `shAmt` (0 to 31). A result that leaves the signed range clamps to the limit that matches the sign of `opA` (0x0000AAAA shifted by 16 gives 0x7FFFFFFF).
- R4: Opcode 3 reads {`opExt`, `opA`} as a signed 40-bit value and narrows it to 32 bits with clamping. Extension 0x11 with word 3 gives 0x7FFFFFFF. Extension 0x00 with word 3 gives 3 and raises no overflow. Extension 0xFF with word 0x7FFFFFFF gives 0x80000000.
- R5: Opcodes 4, 5 and 6 return twice the signed product of two 16-bit halves. The one product that overflows, 0x8000 times 0x8000, returns 0x7FFFFFFF and counts as an overflow.
- R6: The multiply opcodes select halves as follows. Opcode 4 takes the low half of `opA` and the low half of `opB`. Opcode 5 takes the high half of `opA` and the low half of `opB`. Opcode 6 takes the low half of `opA` and the high half of `opB`. With opcode 5, `opA` 0x008A0000 and `opB` 0x000000A7 give 0x0000B40C with no overflow.
- R7: The status register reads zero after reset. The flag appears at bit 9 of `statRdData`, and every other bit of `statRdData` always reads 0.
- R8: An operation that clamps while `opValid` is high sets the flag at the next clock edge. A clamping operation with `opValid` low leaves the flag unchanged.
- R9: The flag is sticky. An operation that does not clamp leaves the flag at its previous value.
- R10: A write (`statWrEn` high) loads bit 9 of `statWrData` into the flag at the next edge. If a valid clamping operation occurs in the same cycle, the flag is set.
- R11: Opcode 7 returns `opA` unchanged and never clamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation issued this cycle; qualifies flag setting |
| opCode | input | 3 | Operation select (0 add, 1 sub, 2 shift, 3 narrow, 4/5/6 multiply, 7 pass) |
| opA | input | 32 | First operand, signed |
| opB | input | 32 | Second operand, signed |
| opExt | input | 8 | Upper 8 bits of the 40-bit value for opcode 3 |
| shAmt | input | 5 | Left shift amount |
| result | output | 32 | Clamped result, combinational |
| statWrEn | input | 1 | Status register write strobe |
| statWrData | input | 32 | Status write data; bit 9 is the flag |
| statRdData | output | 32 | Status register contents |

## Verification
The directed cases drive each operation across its boundaries. For add, subtract, shift and narrowing this covers overflow in each direction, which tells the limit chosen by the sign apart from a wrapped result. It also covers an in-range value that must pass through exactly. The multiply is tried with the minus-one squared case on all three half selections, and with a non-clamping product that exposes a wrong choice of halves. The flag is exercised with issue held low, with a write issued alone, with a write colliding with a clamp, and with runs of non-clamping operations after a set. The random part biases operands toward the range limits and the 0x8000 halves, and interleaves writes, so that result values and flag history are compared against a 64-bit reference model.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_SHL    = 3'd2,
    OP_NARROW = 3'd3,
    OP_MUL_LL = 3'd4,
    OP_MUL_HL = 3'd5,
    OP_MUL_LH = 3'd6,
    OP_PASS   = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    UNIT_ADD,
    UNIT_SHL,
    UNIT_NARROW,
    UNIT_MUL,
    UNIT_PASS
  } unit_e;

  // strobes from control to datapath
  typedef struct packed {
    unit_e unitSel;
    logic  negB;   // subtract: invert opB and carry in
    logic  hiA;    // multiply uses upper half of opA
    logic  hiB;    // multiply uses upper half of opB
  } dp_strobe_t;

endpackage

// File: rtl/sat_alu_dp.sv
module sat_alu_dp
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 8,
  parameter int SH_W   = 5
) (
  input  dp_strobe_t          strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [EXT_W-1:0]    opExt,
  input  logic [SH_W-1:0]     shAmt,
  output logic [DATA_W-1:0]   result,
  output logic                ovf
);

  localparam int HALF_W = DATA_W / 2;
  localparam int WIDE_W = DATA_W + EXT_W;
  localparam int DBL_W  = 2 * DATA_W;
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  // ---------------- add / subtract ----------------
  logic [DATA_W-1:0] bAdj;
  logic [DATA_W:0]   sum;
  logic              addOvf;

  always_comb begin
    bAdj   = strobe.negB ? ~opB : opB;
    sum    = {opA[DATA_W-1], opA} + {bAdj[DATA_W-1], bAdj} + {{DATA_W{1'b0}}, strobe.negB};
    addOvf = sum[DATA_W] ^ sum[DATA_W-1];
  end

  // ---------------- left shift ----------------
  logic [DBL_W-1:0]  shWide;
  logic [DATA_W:0]   shTop;
  logic              shOvf;

  always_comb begin
    shWide = {{DATA_W{opA[DATA_W-1]}}, opA} << shAmt;
    shTop  = shWide[DBL_W-1:DATA_W-1];
    shOvf  = !((&shTop) || !(|shTop));
  end

  // ---------------- 40-to-32 narrowing ----------------
  logic [WIDE_W-1:0]   wideVal;
  logic [EXT_W:0]      wideTop;
  logic                narOvf;

  always_comb begin
    wideVal = {opExt, opA};
    wideTop = wideVal[WIDE_W-1:DATA_W-1];
    narOvf  = !((&wideTop) || !(|wideTop));
  end

  // ---------------- fractional multiply ----------------
  logic [HALF_W-1:0] mulA, mulB;
  logic [DATA_W-1:0] mulAx, mulBx, prod;
  logic [DATA_W-1:0] prodDbl;
  logic              mulOvf;

  always_comb begin
    mulA    = strobe.hiA ? opA[DATA_W-1:HALF_W] : opA[HALF_W-1:0];
    mulB    = strobe.hiB ? opB[DATA_W-1:HALF_W] : opB[HALF_W-1:0];
    mulAx   = {{HALF_W{mulA[HALF_W-1]}}, mulA};
    mulBx   = {{HALF_W{mulB[HALF_W-1]}}, mulB};
    prod    = mulAx * mulBx;
    prodDbl = {prod[DATA_W-2:0], 1'b0};
    // only min*min reaches 2^(DATA_W-2), whose doubling leaves the range
    mulOvf  = prod[DATA_W-1] ^ prod[DATA_W-2];
  end

  // ---------------- result select and clamp ----------------
  logic [DATA_W-1:0] rawVal;
  logic              rawOvf;
  logic              negSide;

  always_comb begin
    rawVal  = opA;
    rawOvf  = 1'b0;
    negSide = 1'b0;
    case (strobe.unitSel)
      UNIT_ADD: begin
        rawVal  = sum[DATA_W-1:0];
        rawOvf  = addOvf;
        negSide = sum[DATA_W];
      end
      UNIT_SHL: begin
        rawVal  = shWide[DATA_W-1:0];
        rawOvf  = shOvf;
        negSide = opA[DATA_W-1];
      end
      UNIT_NARROW: begin
        rawVal  = opA;
        rawOvf  = narOvf;
        negSide = opExt[EXT_W-1];
      end
      UNIT_MUL: begin
        rawVal  = prodDbl;
        rawOvf  = mulOvf;
        negSide = 1'b0;
      end
      default: begin
        rawVal  = opA;
        rawOvf  = 1'b0;
        negSide = 1'b0;
      end
    endcase
    ovf    = rawOvf;
    result = rawOvf ? (negSide ? NEG_LIM : POS_LIM) : rawVal;
  end

  // a clamped result is always one of the two limits (R1, R2, R3, R4, R5)
  always_comb begin
    if (ovf) begin
      assert_clamp_limit_R1: assert (result == POS_LIM || result == NEG_LIM)
        else $error("clamped result is not a range limit");
    end
  end

  // the pass unit never reports overflow (R11)
  always_comb begin
    if (strobe.unitSel == UNIT_PASS) begin
      assert_pass_no_ovf_R11: assert (!ovf && result == opA)
        else $error("pass unit altered operand");
    end
  end

endmodule

// File: rtl/sat_alu_ctrl.sv
module sat_alu_ctrl
  import sat_alu_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int FLAG_POS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic             dpOvf,
  input  logic             statWrEn,
  input  logic [REG_W-1:0] statWrData,
  output dp_strobe_t       strobe,
  output logic [REG_W-1:0] statRdData
);

  localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(1) << FLAG_POS;

  // ---------------- opcode decode ----------------
  opcode_e opSel;

  always_comb begin
    opSel          = opcode_e'(opCode);
    strobe.unitSel = UNIT_PASS;
    strobe.negB    = 1'b0;
    strobe.hiA     = 1'b0;
    strobe.hiB     = 1'b0;
    case (opSel)
      OP_ADD:    strobe.unitSel = UNIT_ADD;
      OP_SUB:  begin strobe.unitSel = UNIT_ADD; strobe.negB = 1'b1; end
      OP_SHL:    strobe.unitSel = UNIT_SHL;
      OP_NARROW: strobe.unitSel = UNIT_NARROW;
      OP_MUL_LL: strobe.unitSel = UNIT_MUL;
      OP_MUL_HL: begin strobe.unitSel = UNIT_MUL; strobe.hiA = 1'b1; end
      OP_MUL_LH: begin strobe.unitSel = UNIT_MUL; strobe.hiB = 1'b1; end
      default:   strobe.unitSel = UNIT_PASS;
    endcase
  end

  // ---------------- sticky status register ----------------
  logic             satHit;
  logic [REG_W-1:0] statReg, statNext;

  always_comb begin
    satHit = opValid && dpOvf;
    if (satHit)        statNext = statReg | FLAG_MASK;
    else if (statWrEn) statNext = statWrData & FLAG_MASK;
    else               statNext = statReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statReg <= '0;
    else       statReg <= statNext;
  end

  assign statRdData = statReg;

  // ---------------- assertions ----------------
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statRdData & ~FLAG_MASK) == '0)
    else $error("reserved status bit set");

  assert_sat_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && dpOvf) |=> statRdData[FLAG_POS])
    else $error("clamp did not set flag");

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statRdData[FLAG_POS] && !statWrEn) |=> statRdData[FLAG_POS])
    else $error("flag dropped without a write");

  assert_no_spurious_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!statRdData[FLAG_POS] && !(opValid && dpOvf) && !(statWrEn && statWrData[FLAG_POS]))
      |=> !statRdData[FLAG_POS])
    else $error("flag rose without cause");

  assert_write_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statWrEn && !statWrData[FLAG_POS] && !(opValid && dpOvf)) |=> !statRdData[FLAG_POS])
    else $error("write of zero did not clear flag");

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EXT_W    = 8,
  parameter int SH_W     = 5,
  parameter int FLAG_POS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [EXT_W-1:0]  opExt,
  input  logic [SH_W-1:0]   shAmt,
  output logic [DATA_W-1:0] result,
  input  logic              statWrEn,
  input  logic [DATA_W-1:0] statWrData,
  output logic [DATA_W-1:0] statRdData
);

  dp_strobe_t strobe;
  logic       dpOvf;

  sat_alu_ctrl #(
    .REG_W    (DATA_W),
    .FLAG_POS (FLAG_POS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opCode     (opCode),
    .dpOvf      (dpOvf),
    .statWrEn   (statWrEn),
    .statWrData (statWrData),
    .strobe     (strobe),
    .statRdData (statRdData)
  );

  sat_alu_dp #(
    .DATA_W (DATA_W),
    .EXT_W  (EXT_W),
    .SH_W   (SH_W)
  ) u_dp (
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .opExt  (opExt),
    .shAmt  (shAmt),
    .result (result),
    .ovf    (dpOvf)
  );

endmodule

// File: tb/sat_alu_bench.sv
`timescale 1ns/1ps
module sat_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd7;
  logic [31:0] opA = '0, opB = '0;
  logic [7:0]  opExt = '0;
  logic [4:0]  shAmt = '0;
  logic [31:0] result;
  logic        statWrEn = 1'b0;
  logic [31:0] statWrData = '0;
  logic [31:0] statRdData;

  int checks = 0;
  int failures = 0;
  bit modelFlag = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sat_alu u_sat_alu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .opExt(opExt), .shAmt(shAmt), .result(result),
    .statWrEn(statWrEn), .statWrData(statWrData), .statRdData(statRdData)
  );

  // reference model from the requirements, using 64-bit arithmetic
  function automatic logic [31:0] refModel(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [7:0] ext, input logic [4:0] sh, output bit clip);
    longint v;
    case (op)
      3'd0: v = longint'($signed(a)) + longint'($signed(b));
      3'd1: v = longint'($signed(a)) - longint'($signed(b));
      3'd2: v = longint'($signed(a)) <<< sh;
      3'd3: v = longint'($signed({ext, a}));
      3'd4: v = 2 * longint'($signed(a[15:0]))  * longint'($signed(b[15:0]));
      3'd5: v = 2 * longint'($signed(a[31:16])) * longint'($signed(b[15:0]));
      3'd6: v = 2 * longint'($signed(a[15:0]))  * longint'($signed(b[31:16]));
      default: v = longint'($signed(a));
    endcase
    clip = 1'b1;
    if (v > 64'sd2147483647)       return 32'h7FFFFFFF;
    else if (v < -64'sd2147483648) return 32'h80000000;
    clip = 1'b0;
    return v[31:0];
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check result, then check status after the edge
  task automatic step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic [7:0] ext, input logic [4:0] sh, input bit valid,
      input bit wr, input logic [31:0] wrData, input string flagReq);
    logic [31:0] expRes;
    bit clip;
    @(negedge clk);
    opCode = op; opA = a; opB = b; opExt = ext; shAmt = sh;
    opValid = valid; statWrEn = wr; statWrData = wrData;
    #1;
    expRes = refModel(op, a, b, ext, sh, clip);
    check32(reqOf(op), result, expRes);
    @(posedge clk);
    #1;
    if (valid && clip) modelFlag = 1'b1;
    else if (wr)       modelFlag = wrData[9];
    check32(flagReq, statRdData, {22'd0, modelFlag, 9'd0});
    opValid = 1'b0; statWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    step(3'd7, 32'h0, 32'h0, 8'h0, 5'd0, 1'b0, 1'b1, 32'h0, "R10");
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    #1;
    check32("R7", statRdData, 32'h0);  // reset state
    @(negedge clk);
    rstN = 1'b1;

    // R1 both directions and in range
    step(3'd0, 32'h51510000, 32'h51515454, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd0, 32'h80000000, 32'hFFFFFFFF, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd0, 32'hFFFFFFFE, 32'h00000005, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    // R2
    step(3'd1, 32'h00000003, 32'h80000003, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    // R9: in-range ops keep the flag set
    step(3'd1, 32'h00000010, 32'h00000001, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    step(3'd7, 32'h12345678, 32'h0, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    clearFlag();
    step(3'd1, 32'h80000000, 32'h00000001, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    // R3
    step(3'd2, 32'h0000AAAA, 32'h0, 8'h0, 5'd16, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd2, 32'hFFFF8001, 32'h0, 8'h0, 5'd17, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd2, 32'hFFFFFFFF, 32'h0, 8'h0, 5'd31, 1'b1, 1'b0, 32'h0, "R9");
    // R4
    step(3'd3, 32'h00000003, 32'h0, 8'h00, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    step(3'd3, 32'h00000003, 32'h0, 8'h11, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd3, 32'h7FFFFFFF, 32'h0, 8'hFF, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd3, 32'h80000000, 32'h0, 8'hFF, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    // R5 and R6: min*min on each half selection
    step(3'd4, 32'h80008000, 32'h80008000, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd5, 32'h80008000, 32'h80008000, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd6, 32'h80008000, 32'h80008000, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R8");
    clearFlag();
    step(3'd5, 32'h008A0000, 32'h000000A7, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    step(3'd4, 32'h008A0003, 32'h00A7FFFE, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    step(3'd6, 32'h008A0003, 32'h00A7FFFE, 8'h0, 5'd0, 1'b1, 1'b0, 32'h0, "R9");
    // R8: clamping op without issue leaves flag clear
    step(3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 8'h0, 5'd0, 1'b0, 1'b0, 32'h0, "R8");
    // R7 and R10: write of all ones reads back only bit 9
    step(3'd7, 32'h0, 32'h0, 8'h0, 5'd0, 1'b0, 1'b1, 32'hFFFFFFFF, "R7");
    clearFlag();
    step(3'd7, 32'h0, 32'h0, 8'h0, 5'd0, 1'b0, 1'b1, 32'h00000200, "R10");
    // R10: clearing write collides with a clamp, set wins
    step(3'd0, 32'h40000000, 32'h40000000, 8'h0, 5'd0, 1'b1, 1'b1, 32'h0, "R10");
    clearFlag();
    // R11
    step(3'd7, 32'h80000000, 32'h7FFFFFFF, 8'hFF, 5'd31, 1'b1, 1'b0, 32'h0, "R11");

    // constrained random with edge-biased operands
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      logic [2:0] op;
      bit wr, valid;
      a = $urandom();
      b = $urandom();
      case ($urandom_range(0, 5))
        0: a = 32'h7FFFFFFF - $urandom_range(0, 3);
        1: a = 32'h80000000 + $urandom_range(0, 3);
        2: begin a = {16'h8000, 16'h8000}; b = {16'h8000, 16'h8000}; end
        3: a = a >> $urandom_range(0, 31);
        default: ;
      endcase
      op    = 3'($urandom_range(0, 7));
      valid = ($urandom_range(0, 7) != 0);
      wr    = ($urandom_range(0, 7) == 0);
      step(op, a, b, 8'($urandom()), 5'($urandom()), valid, wr, $urandom(), "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule